// File: doc/BRIEF.md
# SMII Receive Segment Decoder

This block sits at the MAC end of a serial media-independent link and turns the single receive wire back into byte-wide data plus PHY status. It runs on the one reference clock shared with the PHY. It produces the segment-start pulse itself, so segment timing is fixed by the block. Every 10-bit segment begins in the cycle that the pulse is high. The second bit of a segment selects its format. When that bit is set, the segment carries one data byte. When it is clear, the segment carries the PHY's in-band status word.

At 100 Mbit/s every segment holds new information. At 10 Mbit/s the PHY sends each segment ten times in a row. The block then decodes only the first segment of each group of ten and skips the other nine. The speed is chosen by a plain control pin.

The data output is a one-cycle strobe with the byte beside it. It has no back-pressure: there is no ready signal, because the serial line cannot be paused. The sink must take the byte in the cycle the strobe is high. The strobe comes at most once per segment time.

Top module: `smii_rx_decoder`

## Requirements
- R1: `sync_out` is high for exactly one cycle out of every 10, starting in the first cycle after reset is released. The line bit sampled in the cycle where `sync_out` is high is segment bit 1.
- R2: On every accepted segment, `rx_crs` takes segment bit 1 and `rx_dv` takes segment bit 2.
- R3: An accepted segment with bit 2 = 1 puts segment bits 3..10 onto `byte_data`, least significant bit first. Bits 3..6 are the first MII nibble and form `byte_data[3:0]`. `byte_valid` is high for exactly one cycle: the cycle after bit 10 is sampled, which is also the next cycle in which `sync_out` is high.
- R4: An accepted segment with bit 2 = 0 loads the status outputs from fixed bit positions: bit 3 goes to `rx_err`, bit 4 to `speed_100` (1 = 100 Mbit/s), bit 5 to `full_duplex`, bit 6 to `link_up` and bit 7 to `jabber`. Bits 8, 9 and 10 have no effect on any output.
- R5: `rx_err`, `speed_100`, `full_duplex`, `link_up` and `jabber` keep their values while data segments are decoded. They change only at a segment boundary.
- R6: `frame_end` pulses for one cycle on the first accepted status segment that follows an accepted data segment. A status segment that follows another status segment does not raise it.
- R7: With `mode_100` = 1, every segment is accepted.
- R8: With `mode_100` = 0, the first segment after reset is accepted, then every tenth segment after it. The nine segments in between change no output and produce no strobe.
- R9: A low `rst_n` at a clock edge clears every data and status output to zero and restarts the segment phase, so `sync_out` is high in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, shared with the PHY |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_100 | input | 1 | 1 = 100 Mbit/s (every segment decoded); 0 = 10 Mbit/s (one segment in ten decoded) |
| rx_serial | input | 1 | Serial receive line from the PHY |
| sync_out | output | 1 | Segment-start pulse to the PHY |
| byte_valid | output | 1 | One-cycle strobe marking a new received byte |
| byte_data | output | 8 | Received byte |
| rx_crs | output | 1 | Carrier sense from the last accepted segment |
| rx_dv | output | 1 | Data-valid bit from the last accepted segment |
| rx_err | output | 1 | Receive error from the last status segment |
| frame_end | output | 1 | One-cycle pulse on the first status segment after data |
| link_up | output | 1 | Link indication from the last status segment |
| speed_100 | output | 1 | Speed indication from the last status segment |
| full_duplex | output | 1 | Duplex indication from the last status segment |
| jabber | output | 1 | Jabber indication from the last status segment |

## Verification
The frame-end pulse and a refresh of the status outputs happen on the same clock edge, because both come from the status segment that closes a frame. The bench provokes this by sending data segments and then a status segment whose link and duplex values differ from those already held. In that one sampled cycle it expects `frame_end` high, the new status values in place, and no byte strobe. The byte strobe also always falls in the same cycle as the next segment-start pulse, and the bench checks both together.

// File: rtl/smii_rx_pkg.sv
`timescale 1ns/1ps
package smii_rx_pkg;
  // Segment bit positions (index 0 = segment bit 1), fixed by the line format
  localparam int IDX_CRS = 0;
  localparam int IDX_DV  = 1;
  localparam int IDX_D0  = 2;
  localparam int IDX_ERR = 2;
  localparam int IDX_SPD = 3;
  localparam int IDX_DUP = 4;
  localparam int IDX_LNK = 5;
  localparam int IDX_JAB = 6;

  typedef struct packed {
    logic jabber;
    logic link;
    logic duplex;
    logic speed;
    logic err;
  } phy_stat_t;
endpackage

// File: rtl/smii_rx_timing.sv
`timescale 1ns/1ps
module smii_rx_timing #(
  parameter int SEG_LEN = 10,
  parameter int REPEAT  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_100,
  output logic [$clog2(SEG_LEN)-1:0] pos,
  output logic sync,
  output logic seg_last,
  output logic accept
);
  localparam int PW = $clog2(SEG_LEN);
  localparam int RW = (REPEAT > 1) ? $clog2(REPEAT) : 1;

  logic [RW-1:0] rep;

  assign sync     = (pos == '0);
  assign seg_last = (pos == PW'(SEG_LEN - 1));
  assign accept   = seg_last && (mode_100 || rep == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      rep <= '0;
    end else begin
      pos <= seg_last ? '0 : pos + 1'b1;
      if (mode_100)
        rep <= '0;
      else if (seg_last)
        rep <= (rep == RW'(REPEAT - 1)) ? '0 : rep + 1'b1;
    end
  end
endmodule

// File: rtl/smii_rx_capture.sv
`timescale 1ns/1ps
module smii_rx_capture #(
  parameter int SEG_LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [$clog2(SEG_LEN)-1:0] pos,
  input  logic bit_in,
  output logic [SEG_LEN-1:0] seg_word
);
  localparam int PW = $clog2(SEG_LEN);

  logic [SEG_LEN-2:0] held;

  // each earlier bit parks in its own slot; the last bit is used live
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
    end else begin
      for (int k = 0; k < SEG_LEN - 1; k++)
        if (pos == PW'(k)) held[k] <= bit_in;
    end
  end

  assign seg_word = {bit_in, held};
endmodule

// File: rtl/smii_rx_decode.sv
`timescale 1ns/1ps
module smii_rx_decode
  import smii_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic [DATA_W+1:0] seg_word,
  output logic byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic rx_crs,
  output logic rx_dv,
  output logic frame_end,
  output phy_stat_t stat
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      rx_crs     <= 1'b0;
      rx_dv      <= 1'b0;
      frame_end  <= 1'b0;
      stat       <= '0;
    end else begin
      byte_valid <= 1'b0;
      frame_end  <= 1'b0;
      if (accept) begin
        rx_crs <= seg_word[IDX_CRS];
        rx_dv  <= seg_word[IDX_DV];
        if (seg_word[IDX_DV]) begin
          byte_data  <= seg_word[IDX_D0 +: DATA_W];
          byte_valid <= 1'b1;
        end else begin
          stat.err    <= seg_word[IDX_ERR];
          stat.speed  <= seg_word[IDX_SPD];
          stat.duplex <= seg_word[IDX_DUP];
          stat.link   <= seg_word[IDX_LNK];
          stat.jabber <= seg_word[IDX_JAB];
          frame_end   <= rx_dv;   // previous accepted segment was data
        end
      end
    end
  end
endmodule

// File: rtl/smii_rx_decoder.sv
`timescale 1ns/1ps
module smii_rx_decoder
  import smii_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REPEAT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_100,
  input  logic rx_serial,
  output logic sync_out,
  output logic byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic rx_crs,
  output logic rx_dv,
  output logic rx_err,
  output logic frame_end,
  output logic link_up,
  output logic speed_100,
  output logic full_duplex,
  output logic jabber
);
  localparam int SEG_LEN = DATA_W + 2;
  localparam int PW      = $clog2(SEG_LEN);

  logic [PW-1:0]      pos;
  logic               seg_last;
  logic               accept;
  logic [SEG_LEN-1:0] seg_word;
  phy_stat_t          stat;

  smii_rx_timing #(.SEG_LEN(SEG_LEN), .REPEAT(REPEAT)) u_timing (
    .clk(clk), .rst_n(rst_n), .mode_100(mode_100),
    .pos(pos), .sync(sync_out), .seg_last(seg_last), .accept(accept)
  );

  smii_rx_capture #(.SEG_LEN(SEG_LEN)) u_capture (
    .clk(clk), .rst_n(rst_n), .pos(pos), .bit_in(rx_serial), .seg_word(seg_word)
  );

  smii_rx_decode #(.DATA_W(DATA_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .accept(accept), .seg_word(seg_word),
    .byte_valid(byte_valid), .byte_data(byte_data), .rx_crs(rx_crs),
    .rx_dv(rx_dv), .frame_end(frame_end), .stat(stat)
  );

  assign rx_err      = stat.err;
  assign link_up     = stat.link;
  assign speed_100   = stat.speed;
  assign full_duplex = stat.duplex;
  assign jabber      = stat.jabber;
endmodule

// File: rtl/smii_rx_decoder_chk.sv
`timescale 1ns/1ps
module smii_rx_decoder_chk #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic sync_out,
  input logic byte_valid,
  input logic rx_dv,
  input logic frame_end,
  input logic rx_err,
  input logic link_up,
  input logic speed_100,
  input logic full_duplex,
  input logic jabber
);
  localparam int SEG_LEN = DATA_W + 2;
  localparam int CW = $clog2(SEG_LEN);

  logic [CW-1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= (cyc == CW'(SEG_LEN - 1)) ? '0 : cyc + 1'b1;
  end

  logic [4:0] st;
  assign st = {rx_err, link_up, speed_100, full_duplex, jabber};

  // R1: segment start pulse cadence
  p_sync_cadence_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out == (cyc == '0));

  // R3: strobe only at a segment boundary, one cycle wide
  p_strobe_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> sync_out);
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R2: a strobed byte carries data-valid
  p_dv_with_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> rx_dv);

  // R5: status moves only at boundaries and never on a data segment
  p_stat_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_out |-> $stable(st));
  p_stat_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $stable(st));

  // R6: frame end comes from a status segment
  p_frame_end_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (!rx_dv && !byte_valid && sync_out));
endmodule

bind smii_rx_decoder smii_rx_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_out(sync_out), .byte_valid(byte_valid),
  .rx_dv(rx_dv), .frame_end(frame_end), .rx_err(rx_err), .link_up(link_up),
  .speed_100(speed_100), .full_duplex(full_duplex), .jabber(jabber)
);

// File: tb/smii_rx_decoder_tb.sv
`timescale 1ns/1ps
module smii_rx_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_100 = 1'b1;
  logic rx_serial = 1'b0;
  logic sync_out, byte_valid, rx_crs, rx_dv, rx_err, frame_end;
  logic link_up, speed_100, full_duplex, jabber;
  logic [7:0] byte_data;

  int n_chk = 0;
  int n_fail = 0;
  int mid_strobes = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  smii_rx_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .mode_100(mode_100), .rx_serial(rx_serial),
    .sync_out(sync_out), .byte_valid(byte_valid), .byte_data(byte_data),
    .rx_crs(rx_crs), .rx_dv(rx_dv), .rx_err(rx_err), .frame_end(frame_end),
    .link_up(link_up), .speed_100(speed_100), .full_duplex(full_duplex),
    .jabber(jabber)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] data_seg(input logic crs, input logic [7:0] b);
    return {b, 1'b1, crs};
  endfunction

  function automatic logic [9:0] stat_seg(input logic crs, input logic err, input logic spd,
                                          input logic dup, input logic lnk, input logic jab,
                                          input logic [2:0] tail);
    return {tail, jab, lnk, dup, spd, err, 1'b0, crs};
  endfunction

  // Drives one segment starting at a negedge where sync_out is high.
  // Returns at the negedge after bit 10 has been sampled.
  task automatic send_seg(input logic [9:0] seg);
    for (int i = 0; i < 10; i++) begin
      rx_serial = seg[i];
      @(negedge clk);
      if (i < 9 && byte_valid) mid_strobes++;
    end
  endtask

  task automatic do_reset(input logic m100);
    mode_100 = m100;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  logic [4:0] stv;
  assign stv = {rx_err, speed_100, full_duplex, link_up, jabber};

  task automatic t_reset;
    do_reset(1'b1);
    send_seg(stat_seg(1, 1, 1, 1, 1, 1, 3'b101));
    check("R9 status set before reset", stv, 5'b11111);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 status cleared", stv, 5'b00000);
    check("R9 data cleared", {byte_valid, byte_data, rx_crs, rx_dv, frame_end}, '0);
    rst_n = 1'b1;
    check("R9 R1 sync after release", sync_out, 1'b1);
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      check("R1 sync low mid-segment", sync_out, 1'b0);
    end
    @(negedge clk);
    check("R1 sync again after 10", sync_out, 1'b1);
  endtask

  task automatic t_status;
    do_reset(1'b1);
    send_seg(stat_seg(1, 1, 1, 0, 1, 1, 3'b101));
    check("R4 status fields", stv, 5'b11011);
    check("R2 crs from status", rx_crs, 1'b1);
    check("R2 dv low", rx_dv, 1'b0);
    check("R6 no frame end status-status", frame_end, 1'b0);
    send_seg(stat_seg(0, 1, 1, 0, 1, 1, 3'b010));
    check("R4 tail bits no effect", stv, 5'b11011);
    check("R2 crs cleared", rx_crs, 1'b0);
    send_seg(stat_seg(0, 0, 0, 1, 0, 0, 3'b101));
    check("R4 status fields second", stv, 5'b00100);
    check("R6 no frame end again", frame_end, 1'b0);
  endtask

  task automatic t_data;
    do_reset(1'b1);
    send_seg(stat_seg(1, 0, 1, 0, 1, 0, 3'b101));
    send_seg(data_seg(1, 8'hA5));
    check("R3 strobe", byte_valid, 1'b1);
    check("R3 strobe with sync", sync_out, 1'b1);
    check("R3 byte lsb first", byte_data, 8'hA5);
    check("R2 dv high", rx_dv, 1'b1);
    check("R5 status held on data", stv, 5'b01010);
    send_seg(data_seg(0, 8'h3C));
    check("R7 back-to-back strobe", byte_valid, 1'b1);
    check("R3 nibble order", byte_data, 8'h3C);
    check("R2 crs low on data", rx_crs, 1'b0);
    check("R5 status held second", stv, 5'b01010);
    send_seg(stat_seg(1, 0, 1, 1, 0, 0, 3'b101));
    check("R6 frame end", frame_end, 1'b1);
    check("R6 no strobe on status", byte_valid, 1'b0);
    check("R4 status refreshed with frame end", stv, 5'b01100);
    check("R3 byte held", byte_data, 8'h3C);
    send_seg(stat_seg(1, 0, 1, 1, 0, 0, 3'b101));
    check("R6 single frame end", frame_end, 1'b0);
    check("R3 single-cycle strobe", mid_strobes, 0);
  endtask

  task automatic t_slow;
    do_reset(1'b0);
    send_seg(data_seg(1, 8'h11));
    check("R8 first accepted", byte_valid, 1'b1);
    check("R8 first byte", byte_data, 8'h11);
    for (int s = 1; s < 10; s++) begin
      if (s % 2 == 1) send_seg(stat_seg(0, 1, 1, 1, 1, 1, 3'b101));
      else            send_seg(data_seg(0, 8'h77));
      check("R8 repeat no strobe", byte_valid, 1'b0);
      check("R8 repeat byte unchanged", byte_data, 8'h11);
      check("R8 repeat status unchanged", {stv, rx_crs, rx_dv}, 7'b0000011);
    end
    send_seg(data_seg(0, 8'h22));
    check("R8 tenth accepted", byte_valid, 1'b1);
    check("R8 tenth byte", byte_data, 8'h22);
    check("R8 tenth crs", rx_crs, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R9 sync during reset", sync_out, 1'b1);
    t_reset();
    t_status();
    t_data();
    t_slow();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule